// File: doc/BRIEF.md
# NaN Classify and Quiet Unit

This unit inspects one floating-point word per cycle and tells whether it is a NaN, and if so whether it is quiet or signaling. Four encodings are supported: half, bfloat16, single and double. From the same word it builds a quieted copy, in which a signaling NaN is turned into a quiet one and any other value passes through unchanged. It also builds the canonical default NaN for the selected format.

Two run-time controls shape the result. One inverts the meaning of the fraction's top bit, so that a set top bit marks a signaling NaN rather than a quiet one. The other turns signaling NaNs off altogether. All results leave through a single register stage qualified by a valid bit.

Top module: `nan_screen_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid` is 0 after that edge.
- R2: `out_valid` after each edge equals `in_valid` before it. Results appear one cycle after an accepted word. When `in_valid` is low, every data output holds its previous value.
- R3: `in_fmt` selects the encoding: 0 is half (5 exponent bits, 10 fraction bits), 1 is bfloat16 (8, 7), 2 is single (8, 23) and 3 is double (11, 52). A narrower word occupies the low bits of `in_word`. Input bits above it are ignored, and output bits above it are 0.
- R4: `out_is_nan` is 1 exactly when the exponent field is all ones and the fraction is non-zero, whatever the two controls are.
- R5: With `cfg_snan_inv`=0 and `cfg_snan_off`=0, a NaN is quiet when the fraction's top bit is 1. It is signaling when that bit is 0 and the lower fraction bits are non-zero.
- R6: With `cfg_snan_inv`=1 and `cfg_snan_off`=0, a word is signaling when its exponent is all ones and its fraction's top bit is 1. It is quiet when that bit is 0 and the lower fraction bits are non-zero.
- R7: With `cfg_snan_off`=1, `out_is_snan` is 0 and `out_is_qnan` equals `out_is_nan`, whatever `cfg_snan_inv` is. The quieted word then equals the input.
- R8: In the normal sense, a signaling NaN is quieted by setting the fraction's top bit. Every other input appears on `out_quieted` unchanged.
- R9: In the inverted sense, a signaling NaN is quieted by clearing the fraction's top bit and setting the bit just below it.
- R10: The default NaN has sign 0 and an all-ones exponent. When the inverted sense is off, or when signaling NaNs are disabled, its fraction has only the top bit set. For example, single gives 0x7FC00000.
- R11: With `cfg_snan_inv`=1 and `cfg_snan_off`=0, the default NaN fraction has every bit set except the top one. For example, single gives 0x7FBFFFFF.
- R12: On a valid output, `out_is_qnan` and `out_is_snan` are never both 1, and their OR equals `out_is_nan`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is present |
| in_fmt | input | 2 | Format code |
| in_word | input | 64 | Floating-point word, right-aligned |
| cfg_snan_inv | input | 1 | Fraction top bit set means signaling |
| cfg_snan_off | input | 1 | Treat every NaN as quiet |
| out_valid | output | 1 | Result registers hold a new result |
| out_is_nan | output | 1 | Word is some NaN |
| out_is_qnan | output | 1 | Word is a quiet NaN |
| out_is_snan | output | 1 | Word is a signaling NaN |
| out_quieted | output | 64 | Input with a signaling NaN made quiet |
| out_dflt_nan | output | 64 | Default NaN for the format and controls |

## Verification
Classification and quieting act on the same word in the same cycle. Their coupling shows when a signaling NaN arrives, because the flag and the rewritten fraction must agree. The bench provokes this in both polarity senses and with an input sign of 1. It then checks in one sample that the signaling flag is raised and that the quieted word has exactly the expected fraction bits changed. Default-NaN generation also shares that cycle. Its pattern is judged against the same control setting, including the case where disabling overrides inversion.

// File: rtl/nanq_pkg.sv
package nanq_pkg;

    localparam int WORD_W  = 64;
    localparam int NUM_FMT = 4;
    localparam int FMT_W   = $clog2(NUM_FMT);

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [FMT_W-1:0] {
        FMT_HALF   = 2'd0,
        FMT_BF16   = 2'd1,
        FMT_SINGLE = 2'd2,
        FMT_DOUBLE = 2'd3
    } fmt_e;

    typedef struct packed {
        logic inverted;
        logic disabled;
    } ctrl_t;

    typedef struct packed {
        logic exp_ones;
        logic frac_top;
        logic frac_low_nz;
    } fields_t;

    typedef struct packed {
        logic is_nan;
        logic is_qnan;
        logic is_snan;
    } class_t;

    typedef struct packed {
        class_t cls;
        word_t  quieted;
        word_t  dflt;
    } result_t;

    function automatic int frac_w_of(int code);
        case (code)
            0:       return 10;
            1:       return 7;
            2:       return 23;
            default: return 52;
        endcase
    endfunction

    function automatic int exp_w_of(int code);
        case (code)
            0:       return 5;
            1:       return 8;
            2:       return 8;
            default: return 11;
        endcase
    endfunction

    function automatic word_t low_mask(int n);
        word_t m;
        for (int i = 0; i < WORD_W; i++) begin
            m[i] = (i < n);
        end
        return m;
    endfunction

    function automatic word_t one_bit(int n);
        word_t m;
        m = '0;
        m[n] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/nanq_field_split.sv
module nanq_field_split
    import nanq_pkg::*;
(
    input  fmt_e    fmt,
    input  word_t   word,
    output fields_t fields
);

    fields_t per_fmt [NUM_FMT];

    for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
        localparam int FW = frac_w_of(g);
        localparam int EW = exp_w_of(g);
        assign per_fmt[g].exp_ones    = &word[FW+EW-1:FW];
        assign per_fmt[g].frac_top    = word[FW-1];
        assign per_fmt[g].frac_low_nz = |word[FW-2:0];
    end

    assign fields = per_fmt[fmt];

endmodule

// File: rtl/nanq_classify.sv
module nanq_classify
    import nanq_pkg::*;
(
    input  fields_t fields,
    input  ctrl_t   ctrl,
    output class_t  cls
);

    logic any_nan;

    assign any_nan = fields.exp_ones & (fields.frac_top | fields.frac_low_nz);

    always_comb begin
        cls.is_nan = any_nan;
        if (ctrl.disabled) begin
            cls.is_qnan = any_nan;
            cls.is_snan = 1'b0;
        end else if (ctrl.inverted) begin
            cls.is_snan = fields.exp_ones & fields.frac_top;
            cls.is_qnan = fields.exp_ones & ~fields.frac_top & fields.frac_low_nz;
        end else begin
            cls.is_qnan = fields.exp_ones & fields.frac_top;
            cls.is_snan = fields.exp_ones & ~fields.frac_top & fields.frac_low_nz;
        end
    end

endmodule

// File: rtl/nanq_quiet_gen.sv
module nanq_quiet_gen
    import nanq_pkg::*;
(
    input  fmt_e  fmt,
    input  word_t word,
    input  logic  is_snan,
    input  ctrl_t ctrl,
    output word_t quieted,
    output word_t dflt
);

    word_t q_per [NUM_FMT];
    word_t d_per [NUM_FMT];
    logic  use_inv_pattern;

    assign use_inv_pattern = ctrl.inverted & ~ctrl.disabled;

    for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
        localparam int    FW   = frac_w_of(g);
        localparam int    EW   = exp_w_of(g);
        localparam int    TW   = FW + EW + 1;
        localparam word_t KEEP = low_mask(TW);
        localparam word_t TOP  = one_bit(FW - 1);
        localparam word_t NEXT = one_bit(FW - 2);
        localparam word_t EXPF = low_mask(EW) << FW;

        always_comb begin
            q_per[g] = word & KEEP;
            if (is_snan) begin
                if (ctrl.inverted) begin
                    q_per[g] = (q_per[g] & ~TOP) | NEXT;
                end else begin
                    q_per[g] = q_per[g] | TOP;
                end
            end
            d_per[g] = EXPF | (use_inv_pattern ? low_mask(FW - 1) : TOP);
        end
    end

    assign quieted = q_per[fmt];
    assign dflt    = d_per[fmt];

endmodule

// File: rtl/nan_screen_unit.sv
module nan_screen_unit
    import nanq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [1:0]  in_fmt,
    input  logic [63:0] in_word,
    input  logic        cfg_snan_inv,
    input  logic        cfg_snan_off,
    output logic        out_valid,
    output logic        out_is_nan,
    output logic        out_is_qnan,
    output logic        out_is_snan,
    output logic [63:0] out_quieted,
    output logic [63:0] out_dflt_nan
);

    fmt_e    fmt;
    ctrl_t   ctrl;
    fields_t fields;
    result_t nxt;
    result_t held;
    logic    valid_q;

    assign fmt           = fmt_e'(in_fmt);
    assign ctrl.inverted = cfg_snan_inv;
    assign ctrl.disabled = cfg_snan_off;

    nanq_field_split u_split (
        .fmt    (fmt),
        .word   (in_word),
        .fields (fields)
    );

    nanq_classify u_class (
        .fields (fields),
        .ctrl   (ctrl),
        .cls    (nxt.cls)
    );

    nanq_quiet_gen u_quiet (
        .fmt     (fmt),
        .word    (in_word),
        .is_snan (nxt.cls.is_snan),
        .ctrl    (ctrl),
        .quieted (nxt.quieted),
        .dflt    (nxt.dflt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            held    <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                held <= nxt;
            end
        end
    end

    assign out_valid    = valid_q;
    assign out_is_nan   = held.cls.is_nan;
    assign out_is_qnan  = held.cls.is_qnan;
    assign out_is_snan  = held.cls.is_snan;
    assign out_quieted  = held.quieted;
    assign out_dflt_nan = held.dflt;

    a_r1_reset_clears: assert property (@(posedge clk) rst |=> !out_valid);

    a_r2_valid_rise: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r2_valid_low: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r12_exclusive: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_is_qnan && out_is_snan));

    a_r12_union: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_is_nan == (out_is_qnan || out_is_snan)));

    a_r7_off_no_snan: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(cfg_snan_off)) |-> !out_is_snan);

    a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(in_fmt) != 2'd3) |->
        (out_quieted[63:32] == 32'd0 && out_dflt_nan[63:32] == 32'd0));

endmodule

// File: tb/nan_screen_unit_tb_top.sv
`timescale 1ns/1ps
module nan_screen_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  in_fmt;
    logic [63:0] in_word;
    logic        cfg_snan_inv;
    logic        cfg_snan_off;
    logic        out_valid;
    logic        out_is_nan;
    logic        out_is_qnan;
    logic        out_is_snan;
    logic [63:0] out_quieted;
    logic [63:0] out_dflt_nan;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    nan_screen_unit dut_i (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_fmt       (in_fmt),
        .in_word      (in_word),
        .cfg_snan_inv (cfg_snan_inv),
        .cfg_snan_off (cfg_snan_off),
        .out_valid    (out_valid),
        .out_is_nan   (out_is_nan),
        .out_is_qnan  (out_is_qnan),
        .out_is_snan  (out_is_snan),
        .out_quieted  (out_quieted),
        .out_dflt_nan (out_dflt_nan)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference built from the requirement text (R3..R11)
    task automatic model(input int fmt, input logic [63:0] w, input bit inv, input bit off,
                         output bit n, output bit q, output bit s,
                         output logic [63:0] qw, output logic [63:0] dw);
        int ew, fw;
        logic [63:0] frac, expv, emax;
        bit top, low;
        case (fmt)
            0: begin ew = 5;  fw = 10; end
            1: begin ew = 8;  fw = 7;  end
            2: begin ew = 8;  fw = 23; end
            default: begin ew = 11; fw = 52; end
        endcase
        w    = w & ((64'd1 << (ew + fw + 1)) - 64'd1);
        emax = (64'd1 << ew) - 64'd1;
        expv = (w >> fw) & emax;
        frac = w & ((64'd1 << fw) - 64'd1);
        top  = frac[fw-1];
        low  = (frac & ((64'd1 << (fw - 1)) - 64'd1)) != 0;
        n = (expv == emax) && (frac != 0);
        if (off) begin
            q = n; s = 1'b0;
        end else if (inv) begin
            s = (expv == emax) && top;
            q = (expv == emax) && !top && low;
        end else begin
            q = (expv == emax) && top;
            s = (expv == emax) && !top && low;
        end
        qw = w;
        if (s) begin
            if (inv) qw = (w & ~(64'd1 << (fw - 1))) | (64'd1 << (fw - 2));
            else     qw = w | (64'd1 << (fw - 1));
        end
        dw = (emax << fw) | ((inv && !off) ? ((64'd1 << (fw - 1)) - 64'd1) : (64'd1 << (fw - 1)));
    endtask

    task automatic apply(input string req, input int fmt, input logic [63:0] w,
                         input bit inv, input bit off);
        bit n, q, s;
        logic [63:0] qw, dw;
        model(fmt, w, inv, off, n, q, s, qw, dw);
        @(negedge clk);
        in_valid = 1'b1; in_fmt = 2'(fmt); in_word = w;
        cfg_snan_inv = inv; cfg_snan_off = off;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " R2 valid"}, 64'(out_valid), 64'd1);
        chk({req, " R4 nan"},   64'(out_is_nan), 64'(n));
        chk({req, " qnan"},     64'(out_is_qnan), 64'(q));
        chk({req, " snan"},     64'(out_is_snan), 64'(s));
        chk({req, " quieted"},  out_quieted, qw);
        chk({req, " dflt"},     out_dflt_nan, dw);
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b1; in_fmt = 2'd0; in_word = '0;
        cfg_snan_inv = 1'b0; cfg_snan_off = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 out_valid in reset", 64'(out_valid), 64'd0);
        in_valid = 1'b0; rst = 1'b0;
        @(negedge clk);
        chk("R2 idle after reset", 64'(out_valid), 64'd0);
    endtask

    task automatic t_normal;
        apply("R5 half qnan", 0, 64'h7E00, 0, 0);
        chk("R5 half qnan literal", 64'(out_is_qnan), 64'd1);
        apply("R8 half snan", 0, 64'h7C01, 0, 0);
        chk("R8 half quieted literal", out_quieted, 64'h7E01);
        chk("R10 half dflt literal", out_dflt_nan, 64'h7E00);
        apply("R5 bf16 snan", 1, 64'h7F81, 0, 0);
        chk("R10 bf16 dflt literal", out_dflt_nan, 64'h7FC0);
        apply("R5 bf16 qnan", 1, 64'hFFC0, 0, 0);
        apply("R8 single snan neg", 2, 64'hFF800001, 0, 0);
        chk("R8 single quieted literal", out_quieted, 64'hFFC00001);
        chk("R10 single dflt literal", out_dflt_nan, 64'h7FC00000);
        apply("R4 single inf", 2, 64'h7F800000, 0, 0);
        chk("R4 inf not nan", 64'(out_is_nan), 64'd0);
        apply("R8 single normal number", 2, 64'h3F800000, 0, 0);
        apply("R5 double snan", 3, 64'h7FF0000000000001, 0, 0);
        chk("R10 double dflt literal", out_dflt_nan, 64'h7FF8000000000000);
        apply("R5 double qnan", 3, 64'hFFF8000000000000, 0, 0);
    endtask

    task automatic t_inverted;
        apply("R6 half top set", 0, 64'h7E00, 1, 0);
        chk("R9 half quieted literal", out_quieted, 64'h7D00);
        chk("R11 half dflt literal", out_dflt_nan, 64'h7DFF);
        apply("R6 half low only", 0, 64'h7C01, 1, 0);
        chk("R6 half quiet literal", 64'(out_is_qnan), 64'd1);
        apply("R9 single snan", 2, 64'h7FC00000, 1, 0);
        chk("R9 single quieted literal", out_quieted, 64'h7FA00000);
        chk("R11 single dflt literal", out_dflt_nan, 64'h7FBFFFFF);
        apply("R6 bf16 snan", 1, 64'hFFC1, 1, 0);
        chk("R11 bf16 dflt literal", out_dflt_nan, 64'h7FBF);
        apply("R6 double snan", 3, 64'h7FFC000000000000, 1, 0);
        chk("R11 double dflt literal", out_dflt_nan, 64'h7FF7FFFFFFFFFFFF);
        apply("R6 inf", 2, 64'h7F800000, 1, 0);
    endtask

    task automatic t_disabled;
        apply("R7 half low-only", 0, 64'h7C01, 0, 1);
        chk("R7 quieted unchanged", out_quieted, 64'h7C01);
        apply("R7 inv single", 2, 64'h7FC00000, 1, 1);
        chk("R7 snan off", 64'(out_is_snan), 64'd0);
        chk("R10 dflt when off", out_dflt_nan, 64'h7FC00000);
        apply("R7 double non-nan", 3, 64'h4000000000000000, 1, 1);
    endtask

    task automatic t_upper_ignored;
        apply("R3 half upper junk", 0, 64'hDEADBEEF00007C01, 0, 0);
        chk("R3 half quieted literal", out_quieted, 64'h7E01);
        apply("R3 bf16 upper junk", 1, 64'hFFFFFFFFFFFF0001, 0, 0);
        chk("R3 bf16 not nan", 64'(out_is_nan), 64'd0);
        apply("R3 single upper junk", 2, 64'h123456787F800001, 1, 0);
    endtask

    task automatic t_hold;
        logic [63:0] prev_q;
        apply("R2 hold setup", 2, 64'h7F800001, 0, 0);
        prev_q = out_quieted;
        @(negedge clk);
        in_word = 64'h7FC00000; in_fmt = 2'd0; cfg_snan_inv = 1'b1;
        @(negedge clk);
        chk("R2 valid low when idle", 64'(out_valid), 64'd0);
        chk("R2 quieted held", out_quieted, prev_q);
        chk("R2 snan held", 64'(out_is_snan), 64'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_normal();
        t_inverted();
        t_disabled();
        t_upper_ignored();
        t_hold();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule